// File: doc/BRIEF.md
# Sixteen-Bit Shifter With Condition Flags

This block shifts a 16-bit operand by a variable count and produces the complete set of condition flags that an integer pipeline writes back after a shift. Three shift kinds are supported: logical left, logical right and arithmetic right. A fourth operation code passes the operand through unchanged. Only the low five bits of the count take part. Counts of 16 and above follow fixed rules: logical shifts give zero, and an arithmetic shift fills the whole word with the sign.

The shift network and the flag logic are combinational. Their outputs are captured in a single output register stage. That stage loads whenever the issue strobe is high and holds its value otherwise. Each result therefore appears one clock after it is issued, together with a result-valid strobe. A flag-update enable tells the consumer whether the flags should be committed. For a zero effective count the flags must be left alone.

Top module: `shf16_flags`

## Requirements
- R1: Only count bits [4:0] are used. Bits [7:5] of the count have no effect on any output.
- R2: When the masked count is zero, the result equals the operand, the flag-update enable is 0 and every flag output is 0.
- R3: Logical left (op 2'b00), masked count n from 1 to 16: result = (operand << n) truncated to 16 bits, carry = operand bit (16−n), overflow = carry XOR result bit 15.
- R4: Logical left with n above 16: result 0x0000, carry 0, overflow 0.
- R5: Logical right (op 2'b01): result = operand >> n (0x0000 when n ≥ 16). Carry = operand bit (n−1) for n ≤ 16 and 0 above 16. Overflow = result bit 15 XOR result bit 14, which equals the original bit 15 for n = 1 and is 0 otherwise.
- R6: Arithmetic right (op 2'b10) with n from 1 to 15: the vacated upper bits take the operand sign, and carry = operand bit (n−1).
- R7: Arithmetic right with n ≥ 16: result 0xFFFF when operand bit 15 is 1, else 0x0000, and carry equals that sign bit.
- R8: Arithmetic right always gives overflow 0.
- R9: For every shift with nonzero n: sign = result bit 15, zero = 1 exactly when the result is 0x0000, and parity = 1 when the low result byte holds an even number of ones.
- R10: The auxiliary-carry flag is always 0. The flag-update enable is 1 for any shift op (00, 01, 10) with nonzero n.
- R11: Op 2'b11 acts as a pass-through: the result equals the operand, the flag-update enable is 0 and all flags are 0, whatever the count.
- R12: Outputs change one clock after a cycle with issue high, and result-valid is high in that cycle. After a cycle with issue low, result-valid is 0 and the data outputs hold their previous values. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Capture this cycle's operation |
| op_i | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 pass |
| opnd_i | input | 16 | Operand |
| cnt_i | input | 8 | Shift count; low 5 bits used |
| rvld_o | output | 1 | Result valid |
| res_o | output | 16 | Shifted result |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag (even parity of low byte) |
| af_o | output | 1 | Auxiliary-carry flag |
| fupd_o | output | 1 | Flag-update enable |

## Verification
The only state in the block is the output register. A fault there shows up on the very next clock after issue: a stale or corrupted result, a valid strobe that is missing or extra, or flag bits that do not match the word. A mistake in the combinational network shows up in the same cycle as a wrong result or flag. Such faults are most likely at the count boundaries 1, 15, 16 and 17, and for the sign-bit operands 0x8000, 0x7FFF and 0xFFFF. For that reason every count is swept against those operands as well as against random ones.

// File: rtl/shf16_pkg.sv
package shf16_pkg;
  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_ARITH = 2'b10,
    SH_PASS  = 2'b11
  } shop_e;
endpackage

// File: rtl/shf16_core.sv
module shf16_core
  import shf16_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  shop_e          op,
  input  logic [W-1:0]   a,
  input  logic [CW-1:0]  cnt,
  output logic [W-1:0]   res,
  output logic           cf,
  output logic           of,
  output logic           act
);
  localparam int MB = $clog2(2 * W);

  logic [MB-1:0]  n;
  logic [2*W-1:0] wl, wr, wa;

  assign n = cnt[MB-1:0];

  always_comb begin
    wl = {{W{1'b0}}, a} << n;
    wr = {a, {W{1'b0}}} >> n;
    wa = $signed({a, {W{1'b0}}}) >>> n;
  end

  always_comb begin
    res = a;
    cf  = 1'b0;
    of  = 1'b0;
    act = 1'b0;
    if (n != '0) begin
      unique case (op)
        SH_LEFT: begin
          res = wl[W-1:0];
          cf  = wl[W];
          of  = wl[W] ^ wl[W-1];
          act = 1'b1;
        end
        SH_RIGHT: begin
          res = wr[2*W-1:W];
          cf  = wr[W-1];
          of  = wr[2*W-1] ^ wr[2*W-2];
          act = 1'b1;
        end
        SH_ARITH: begin
          res = wa[2*W-1:W];
          cf  = wa[W-1];
          of  = 1'b0;
          act = 1'b1;
        end
        default: begin
          res = a;
        end
      endcase
    end
  end
endmodule

// File: rtl/shf16_flags_gen.sv
module shf16_flags_gen #(
  parameter int W = 16
) (
  input  logic [W-1:0] res,
  input  logic         act,
  output logic         sf,
  output logic         zf,
  output logic         pf,
  output logic         af
);
  always_comb begin
    sf = act & res[W-1];
    zf = act & (res == '0);
    pf = act & ~(^res[7:0]);
    af = 1'b0;
  end
endmodule

// File: rtl/shf16_flags.sv
module shf16_flags
  import shf16_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [1:0]    op_i,
  input  logic [W-1:0]  opnd_i,
  input  logic [CW-1:0] cnt_i,
  output logic          rvld_o,
  output logic [W-1:0]  res_o,
  output logic          cf_o,
  output logic          of_o,
  output logic          sf_o,
  output logic          zf_o,
  output logic          pf_o,
  output logic          af_o,
  output logic          fupd_o
);
  localparam int MB = $clog2(2 * W);

  logic [W-1:0] c_res;
  logic         c_cf, c_of, c_act, c_sf, c_zf, c_pf, c_af;

  shf16_core #(.W(W), .CW(CW)) u_core (
    .op  (shop_e'(op_i)),
    .a   (opnd_i),
    .cnt (cnt_i),
    .res (c_res),
    .cf  (c_cf),
    .of  (c_of),
    .act (c_act)
  );

  shf16_flags_gen #(.W(W)) u_flg (
    .res (c_res),
    .act (c_act),
    .sf  (c_sf),
    .zf  (c_zf),
    .pf  (c_pf),
    .af  (c_af)
  );

  // next state
  logic [W-1:0] res_d;
  logic         cf_d, of_d, sf_d, zf_d, pf_d, af_d, upd_d;

  always_comb begin
    res_d = res_o;
    cf_d  = cf_o;
    of_d  = of_o;
    sf_d  = sf_o;
    zf_d  = zf_o;
    pf_d  = pf_o;
    af_d  = af_o;
    upd_d = fupd_o;
    if (issue_i) begin
      res_d = c_res;
      cf_d  = c_cf;
      of_d  = c_of;
      sf_d  = c_sf;
      zf_d  = c_zf;
      pf_d  = c_pf;
      af_d  = c_af;
      upd_d = c_act;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_o <= 1'b0;
      res_o  <= '0;
      cf_o   <= 1'b0;
      of_o   <= 1'b0;
      sf_o   <= 1'b0;
      zf_o   <= 1'b0;
      pf_o   <= 1'b0;
      af_o   <= 1'b0;
      fupd_o <= 1'b0;
    end else begin
      rvld_o <= issue_i;
      res_o  <= res_d;
      cf_o   <= cf_d;
      of_o   <= of_d;
      sf_o   <= sf_d;
      zf_o   <= zf_d;
      pf_o   <= pf_d;
      af_o   <= af_d;
      fupd_o <= upd_d;
    end
  end

  // assertions
  p_zero_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && cnt_i[MB-1:0] == '0) |=> (!fupd_o && res_o == $past(opnd_i)));

  p_left_far_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == SH_LEFT && cnt_i[MB-1:0] > MB'(W)) |=> (res_o == '0 && !cf_o));

  p_sar_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == SH_ARITH && cnt_i[MB-1:0] >= MB'(W))
      |=> (res_o == {W{$past(opnd_i[W-1])}} && cf_o == $past(opnd_i[W-1])));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == SH_ARITH) |=> !of_o);

  p_aux_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rvld_o |-> !af_o);

  p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == SH_PASS) |=> (!fupd_o && res_o == $past(opnd_i)));

  p_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rvld_o == $past(issue_i)));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(res_o));
endmodule

// File: tb/shf16_flags_test.sv
module shf16_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [15:0] opnd_i = 16'h0;
  logic [7:0]  cnt_i = 8'h0;
  logic        rvld_o, cf_o, of_o, sf_o, zf_o, pf_o, af_o, fupd_o;
  logic [15:0] res_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  shf16_flags uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
    .opnd_i(opnd_i), .cnt_i(cnt_i), .rvld_o(rvld_o), .res_o(res_o),
    .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o), .pf_o(pf_o),
    .af_o(af_o), .fupd_o(fupd_o)
  );

  // packed {res, cf, of, sf, zf, pf, af, upd}
  function automatic logic [22:0] model(input int op, input int a, input int cnt);
    int m, r, c, o, ones;
    logic s, z, p, u;
    m = cnt & 31;
    r = a; c = 0; o = 0; s = 0; z = 0; p = 0; u = 0;
    if (op != 3 && m != 0) begin
      u = 1;
      if (op == 0) begin
        r = (m >= 16) ? 0 : ((a << m) & 16'hFFFF);
        c = (m <= 16) ? ((a >> (16 - m)) & 1) : 0;
        o = c ^ ((r >> 15) & 1);
      end else if (op == 1) begin
        r = (m >= 16) ? 0 : (a >> m);
        c = (m <= 16) ? ((a >> (m - 1)) & 1) : 0;
        o = (m == 1) ? ((a >> 15) & 1) : 0;
      end else begin
        if (m >= 16) begin
          r = ((a >> 15) & 1) ? 16'hFFFF : 0;
          c = (a >> 15) & 1;
        end else begin
          r = a;
          for (int k = 0; k < m; k++) r = (r >> 1) | (r & 16'h8000);
          c = (a >> (m - 1)) & 1;
        end
        o = 0;
      end
      s = r[15];
      z = (r == 0);
      ones = 0;
      for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
      p = (ones % 2 == 0);
    end
    return {r[15:0], c[0], o[0], s, z, p, 1'b0, u};
  endfunction

  function automatic string tag_of(input int op, input int cnt);
    int m;
    m = cnt & 31;
    if (op == 3) return "R11";
    if (m == 0) return "R2";
    if (op == 0) return (m > 16) ? "R4" : "R3";
    if (op == 1) return "R5";
    return (m >= 16) ? "R7" : "R6";
  endfunction

  task automatic check_out(input logic [22:0] exp, input string tag);
    logic [22:0] act;
    act = {res_o, cf_o, of_o, sf_o, zf_o, pf_o, af_o, fupd_o};
    n_cmp++;
    if (!rvld_o || act !== exp) begin
      n_bad++;
      $display("FAIL %s: vld=%b got %h expected %h", tag, rvld_o, act, exp);
    end
  endtask

  task automatic apply(input int op, input int a, input int cnt, input string tag);
    @(negedge clk);
    issue_i = 1'b1;
    op_i = op[1:0];
    opnd_i = a[15:0];
    cnt_i = cnt[7:0];
    @(negedge clk);
    issue_i = 1'b0;
    check_out(model(op, a, cnt), tag);
  endtask

  initial begin
    int ops[8];
    logic [22:0] held;
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int vals[8];
    logic [22:0] held;
    repeat (3) @(negedge clk);
    // R12 reset state
    n_cmp++;
    if (rvld_o !== 1'b0 || res_o !== 16'h0 || fupd_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 reset: got vld=%b res=%h expected 0 0", rvld_o, res_o);
    end
    rst_n = 1'b1;

    vals[0] = 16'h8000; vals[1] = 16'h7FFF; vals[2] = 16'hFFFF; vals[3] = 16'h0001;
    vals[4] = 16'h0000;
    for (int op = 0; op < 4; op++) begin
      for (int c = 0; c < 32; c++) begin
        vals[5] = $urandom & 16'hFFFF;
        vals[6] = $urandom & 16'hFFFF;
        vals[7] = $urandom & 16'hFFFF;
        for (int v = 0; v < 8; v++) begin
          apply(op, vals[v], c, tag_of(op, c));
          // R9 and R10 are covered by the same packed comparison
        end
      end
    end

    // R1: upper count bits ignored
    for (int op = 0; op < 3; op++) begin
      for (int c = 0; c < 32; c += 5) begin
        apply(op, 16'hA5C3, c | 8'hE0, "R1");
        apply(op, 16'h8001, c | 8'h20, "R1");
      end
    end

    // R12: hold and valid low after an idle cycle
    apply(0, 16'h1234, 4, "R3");
    held = {res_o, cf_o, of_o, sf_o, zf_o, pf_o, af_o, fupd_o};
    @(negedge clk);
    n_cmp++;
    if (rvld_o !== 1'b0 || {res_o, cf_o, of_o, sf_o, zf_o, pf_o, af_o, fupd_o} !== held) begin
      n_bad++;
      $display("FAIL R12 hold: got vld=%b res=%h expected 0 %h", rvld_o, res_o, held[22:7]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule